// File: doc/BRIEF.md
# Write Merging Burst Buffer

This block sits on the posted-write path from a processor to a slower peripheral bus. It takes byte, halfword and word writes from the processor and stores them in a small buffer. The processor is released as soon as the buffer accepts a write. The buffer later sends its contents downstream as a series of word beats. Each beat carries its own byte enables, so a word that is only partly written updates only the bytes that hold valid data.

When merging is on, a narrow write that targets the same aligned word as the most recently stored entry is folded into that entry. Data is then held back until a burst is worth sending. A burst starts when the buffer is full, when a flush is requested, or when no write has arrived for a programmable number of cycles. Entries at consecutive word addresses then leave as one burst, and any gap in the addresses closes the burst. When merging is off, every write becomes its own entry and is sent as a single-beat transfer as soon as the downstream side can take it.

Top module: `wrmerge_buf`

## Requirements
- R1: After reset `bus_valid_o` is 0 and `wr_ready_o` is 1.
- R2: Byte enables follow `wr_size_i` and the low address bits. Size 00 is a byte and enables lane `wr_addr_i[1:0]`. Size 01 is a halfword and enables 0011 when `wr_addr_i[1]`=0 and 1100 when it is 1, with `wr_addr_i[0]` ignored. Sizes 10 and 11 are a word and enable 1111, with `wr_addr_i[1:0]` ignored. Data is lane-aligned on `wr_data_i`, and `bus_waddr_o` is `wr_addr_i[ADDR_W-1:2]`.
- R3: With `merge_en_i`=1, a write to the same word address as the newest entry adds no new entry. Its enabled bytes overwrite the matching bytes of that entry, and its enables are ORed into that entry's enables.
- R4: With `merge_en_i`=1, `bus_valid_o` stays 0 while fewer than DEPTH entries are held, `flush_i` is low and the idle limit has not been reached.
- R5: With `merge_en_i`=1, once DEPTH entries are held, `wr_ready_o` drops and the buffer drains completely. Writes are refused until the buffer is empty.
- R6: With `merge_en_i`=1, raising `flush_i` while entries are held drains the buffer, and `wr_ready_o` is 0 while `flush_i` is high.
- R7: With `merge_en_i`=1 and limit L on `idle_limit_i`, `bus_valid_o` stays 0 at the L+1 cycle ends after the last accepted write and is 1 at the next one.
- R8: Beats leave in the order the entries were stored. `bus_last_o` is 1 on a beat that is the final held entry, or whose next entry is not at the next word address. Otherwise the next beat carries the next word address.
- R9: With `merge_en_i`=0, each accepted write is its own entry even when it targets the same word. `bus_valid_o` is 1 in the cycle after a write enters an empty buffer, and every beat has `bus_last_o`=1.
- R10: While `bus_valid_o`=1 and `bus_ready_i`=0, the beat's address, data, enables and last flag are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| merge_en_i | input | 1 | 1: merge writes and send bursts; 0: send each write alone |
| flush_i | input | 1 | Request to drain held entries |
| idle_limit_i | input | TMO_W | Idle cycles before held entries are drained |
| wr_valid_i | input | 1 | Processor write request |
| wr_ready_o | output | 1 | Write accepted on this cycle's edge when high |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_size_i | input | 2 | 00 byte, 01 halfword, 1x word |
| wr_data_i | input | 32 | Lane-aligned write data |
| bus_valid_o | output | 1 | Downstream beat valid |
| bus_ready_i | input | 1 | Downstream accepts the beat |
| bus_waddr_o | output | ADDR_W-2 | Word address of the beat |
| bus_data_o | output | 32 | Beat data |
| bus_be_o | output | 4 | Beat byte enables |
| bus_last_o | output | 1 | Final beat of a burst |

## Verification
A wrong merge decision shows up on the first beat after the next drain. It appears as an extra beat, or as enables or data bytes that differ from the ORed and overwritten values. A stuck or early drain flag shows within one cycle as `bus_valid_o` rising while merging is on and no trigger is present, or as `wr_ready_o` staying low after the last beat. A pointer or address error shows as a `bus_last_o` flag that does not match the address continuity of the next beat. The bench checks that continuity on every beat of a gapped burst.

// File: rtl/wrmerge_pkg.sv
package wrmerge_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS  = 8 * WORD_BYTES;

  // size: 00 byte, 01 halfword, 1x word
  function automatic logic [WORD_BYTES-1:0] lane_mask(input logic [1:0] size,
                                                      input logic [1:0] off);
    logic [WORD_BYTES-1:0] m;
    unique case (size)
      2'b00:   m = 4'b0001 << off;
      2'b01:   m = off[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/wrmerge_lane_dec.sv
module wrmerge_lane_dec
  import wrmerge_pkg::*;
(
  input  logic [1:0]            size_i,
  input  logic [1:0]            off_i,
  output logic [WORD_BYTES-1:0] be_o
);
  always_comb be_o = lane_mask(size_i, off_i);
endmodule

// File: rtl/wrmerge_store.sv
module wrmerge_store
  import wrmerge_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WA_W  = 30,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  logic                  merge_i,
  input  logic                  pop_i,
  input  logic [WA_W-1:0]       waddr_i,
  input  logic [WORD_BITS-1:0]  data_i,
  input  logic [WORD_BYTES-1:0] be_i,
  output logic [CW-1:0]         count_o,
  output logic [WA_W-1:0]       head_waddr_o,
  output logic [WORD_BITS-1:0]  head_data_o,
  output logic [WORD_BYTES-1:0] head_be_o,
  output logic [WA_W-1:0]       next_waddr_o,
  output logic [WA_W-1:0]       tail_waddr_o
);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  logic [WA_W-1:0]       addr_q [DEPTH];
  logic [WORD_BITS-1:0]  data_q [DEPTH];
  logic [WORD_BYTES-1:0] be_q   [DEPTH];
  logic [PW-1:0]         wp_q, rp_q, tail_idx, next_idx;
  logic [CW-1:0]         cnt_q;

  assign tail_idx = ptr_dec(wp_q);
  assign next_idx = ptr_inc(rp_q);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[e] <= '0;
        data_q[e] <= '0;
        be_q[e]   <= '0;
      end else if (push_i && wp_q == PW'(e)) begin
        addr_q[e] <= waddr_i;
        data_q[e] <= data_i;
        be_q[e]   <= be_i;
      end else if (merge_i && tail_idx == PW'(e)) begin
        for (int b = 0; b < WORD_BYTES; b++)
          if (be_i[b]) data_q[e][8*b +: 8] <= data_i[8*b +: 8];
        be_q[e] <= be_q[e] | be_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= ptr_inc(wp_q);
      if (pop_i)  rp_q <= ptr_inc(rp_q);
      unique case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count_o      = cnt_q;
  assign head_waddr_o = addr_q[rp_q];
  assign head_data_o  = data_q[rp_q];
  assign head_be_o    = be_q[rp_q];
  assign next_waddr_o = addr_q[next_idx];
  assign tail_waddr_o = addr_q[tail_idx];
endmodule

// File: rtl/wrmerge_ctrl.sv
module wrmerge_ctrl #(
  parameter int DEPTH = 4,
  parameter int TMO_W = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             merge_en_i,
  input  logic             flush_i,
  input  logic [TMO_W-1:0] idle_limit_i,
  input  logic             wr_valid_i,
  input  logic             wr_fire_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [CW-1:0]    count_i,
  output logic             drain_o
);
  logic             drain_q, start, held, full, empty_next;
  logic [TMO_W-1:0] idle_q;

  assign held       = count_i != '0;
  assign full       = count_i == CW'(DEPTH);
  assign start      = merge_en_i && !drain_q && held &&
                      (full || flush_i || (!wr_valid_i && idle_q >= idle_limit_i));
  assign empty_next = count_i == CW'(1) && pop_i && !push_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q <= 1'b0;
      idle_q  <= '0;
    end else begin
      if (start)                             drain_q <= 1'b1;
      else if (drain_q && (empty_next || !held)) drain_q <= 1'b0;

      if (wr_fire_i || !held || drain_q) idle_q <= '0;
      else if (idle_q != '1)             idle_q <= idle_q + 1'b1;
    end
  end

  assign drain_o = drain_q;
endmodule

// File: rtl/wrmerge_buf.sv
module wrmerge_buf
  import wrmerge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  parameter int TMO_W  = 8,
  localparam int WA_W  = ADDR_W - 2,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  merge_en_i,
  input  logic                  flush_i,
  input  logic [TMO_W-1:0]      idle_limit_i,
  input  logic                  wr_valid_i,
  output logic                  wr_ready_o,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [1:0]            wr_size_i,
  input  logic [WORD_BITS-1:0]  wr_data_i,
  output logic                  bus_valid_o,
  input  logic                  bus_ready_i,
  output logic [WA_W-1:0]       bus_waddr_o,
  output logic [WORD_BITS-1:0]  bus_data_o,
  output logic [WORD_BYTES-1:0] bus_be_o,
  output logic                  bus_last_o
);
  logic [WORD_BYTES-1:0] wr_be;
  logic [WA_W-1:0]       wr_waddr, head_waddr, next_waddr, tail_waddr;
  logic [CW-1:0]         count;
  logic                  drain, hit, wr_fire, push, merge, pop;

  assign wr_waddr = wr_addr_i[ADDR_W-1:2];

  wrmerge_lane_dec u_dec (
    .size_i (wr_size_i),
    .off_i  (wr_addr_i[1:0]),
    .be_o   (wr_be)
  );

  // merge only into the newest entry, keeping write order intact
  assign hit        = merge_en_i && count != '0 && tail_waddr == wr_waddr;
  assign wr_ready_o = (count < CW'(DEPTH)) && (!merge_en_i || (!drain && !flush_i));
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign merge      = wr_fire && hit;
  assign push       = wr_fire && !hit;
  assign pop        = bus_valid_o && bus_ready_i;

  wrmerge_store #(.DEPTH(DEPTH), .WA_W(WA_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .merge_i      (merge),
    .pop_i        (pop),
    .waddr_i      (wr_waddr),
    .data_i       (wr_data_i),
    .be_i         (wr_be),
    .count_o      (count),
    .head_waddr_o (head_waddr),
    .head_data_o  (bus_data_o),
    .head_be_o    (bus_be_o),
    .next_waddr_o (next_waddr),
    .tail_waddr_o (tail_waddr)
  );

  wrmerge_ctrl #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .merge_en_i   (merge_en_i),
    .flush_i      (flush_i),
    .idle_limit_i (idle_limit_i),
    .wr_valid_i   (wr_valid_i),
    .wr_fire_i    (wr_fire),
    .push_i       (push),
    .pop_i        (pop),
    .count_i      (count),
    .drain_o      (drain)
  );

  assign bus_valid_o = count != '0 && (drain || !merge_en_i);
  assign bus_waddr_o = head_waddr;
  assign bus_last_o  = !merge_en_i || count == CW'(1) ||
                       next_waddr != head_waddr + 1'b1;
endmodule

// File: rtl/wrmerge_chk.sv
module wrmerge_chk #(
  parameter int WA_W = 30
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            merge_en_i,
  input logic            wr_ready_o,
  input logic            bus_valid_o,
  input logic            bus_ready_i,
  input logic [WA_W-1:0] bus_waddr_o,
  input logic [31:0]     bus_data_o,
  input logic [3:0]      bus_be_o,
  input logic            bus_last_o
);
  // R10
  hold_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_waddr_o) &&
      $stable(bus_data_o) && $stable(bus_be_o) && $stable(bus_last_o)));

  // R5
  no_write_in_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (merge_en_i && bus_valid_o) |-> !wr_ready_o);

  // R9
  single_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!merge_en_i && bus_valid_o) |-> bus_last_o);

  // R8
  burst_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_ready_i && !bus_last_o && merge_en_i) |=>
      (bus_valid_o && bus_waddr_o == $past(bus_waddr_o) + 1'b1));

  // R2
  nonzero_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> bus_be_o != 4'b0000);
endmodule

bind wrmerge_buf wrmerge_chk #(.WA_W(ADDR_W - 2)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .merge_en_i  (merge_en_i),
  .wr_ready_o  (wr_ready_o),
  .bus_valid_o (bus_valid_o),
  .bus_ready_i (bus_ready_i),
  .bus_waddr_o (bus_waddr_o),
  .bus_data_o  (bus_data_o),
  .bus_be_o    (bus_be_o),
  .bus_last_o  (bus_last_o)
);

// File: tb/tb_wrmerge_buf.sv
module tb_wrmerge_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        merge_en_i = 1'b1;
  logic        flush_i = 1'b0;
  logic [7:0]  idle_limit_i = 8'd200;
  logic        wr_valid_i = 1'b0;
  logic        wr_ready_o;
  logic [31:0] wr_addr_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        bus_valid_o;
  logic        bus_ready_i = 1'b0;
  logic [29:0] bus_waddr_o;
  logic [31:0] bus_data_o;
  logic [3:0]  bus_be_o;
  logic        bus_last_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  wrmerge_buf dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    wr_addr_i = a; wr_size_i = sz; wr_data_i = d; wr_valid_i = 1'b1;
    #1;
    for (int n = 0; n < 100 && !wr_ready_o; n++) begin
      @(negedge clk_i); #1;
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic take_beat(input logic [29:0] wa, input logic [3:0] be,
                           input logic [31:0] d, input bit last, input string tag);
    logic [31:0] m;
    for (int n = 0; n < 200 && !bus_valid_o; n++) @(negedge clk_i);
    for (int b = 0; b < 4; b++) m[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
    chk(bus_valid_o === 1'b1, tag, "beat valid", {31'd0, bus_valid_o}, 32'd1);
    chk(bus_waddr_o === wa, tag, "beat word addr", {2'b0, bus_waddr_o}, {2'b0, wa});
    chk(bus_be_o === be, tag, "beat enables", {28'd0, bus_be_o}, {28'd0, be});
    chk((bus_data_o & m) === (d & m), tag, "beat data", bus_data_o & m, d & m);
    chk(bus_last_o === last, tag, "beat last", {31'd0, bus_last_o}, {31'd0, last});
    bus_ready_i = 1'b1;
    @(negedge clk_i);
    bus_ready_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(bus_valid_o === 1'b0, "R1", "valid after reset", {31'd0, bus_valid_o}, 32'd0);
    chk(wr_ready_o === 1'b1, "R1", "ready after reset", {31'd0, wr_ready_o}, 32'd1);
  endtask

  task automatic t_merge_flush;
    cpu_wr(32'h100, 2'b00, 32'h0000_0011);
    cpu_wr(32'h101, 2'b00, 32'h0000_2200);
    cpu_wr(32'h102, 2'b01, 32'h4433_0000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(bus_valid_o === 1'b0, "R4", "held while merging", {31'd0, bus_valid_o}, 32'd0);
    end
    flush_i = 1'b1; #1;
    chk(wr_ready_o === 1'b0, "R6", "ready during flush", {31'd0, wr_ready_o}, 32'd0);
    @(negedge clk_i);
    flush_i = 1'b0;
    take_beat(30'h40, 4'b1111, 32'h4433_2211, 1'b1, "R3");
    @(negedge clk_i);
    chk(bus_valid_o === 1'b0, "R6", "empty after flush", {31'd0, bus_valid_o}, 32'd0);
  endtask

  task automatic t_overwrite_burst;
    cpu_wr(32'h200, 2'b00, 32'h0000_00AA);
    cpu_wr(32'h200, 2'b00, 32'h0000_00BB);
    cpu_wr(32'h203, 2'b00, 32'hCC00_0000);
    cpu_wr(32'h206, 2'b01, 32'h5566_0000);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    take_beat(30'h80, 4'b1001, 32'hCC00_00BB, 1'b0, "R3");
    take_beat(30'h81, 4'b1100, 32'h5566_0000, 1'b1, "R8");
  endtask

  task automatic t_full_gap;
    cpu_wr(32'h300, 2'b10, 32'hA0A0_A0A0);
    cpu_wr(32'h304, 2'b10, 32'hA1A1_A1A1);
    cpu_wr(32'h30C, 2'b10, 32'hA3A3_A3A3);
    cpu_wr(32'h310, 2'b11, 32'hA4A4_A4A4);
    #1;
    chk(wr_ready_o === 1'b0, "R5", "ready when full", {31'd0, wr_ready_o}, 32'd0);
    take_beat(30'hC0, 4'b1111, 32'hA0A0_A0A0, 1'b0, "R8");
    take_beat(30'hC1, 4'b1111, 32'hA1A1_A1A1, 1'b1, "R8");
    #1;
    chk(wr_ready_o === 1'b0, "R5", "ready mid drain", {31'd0, wr_ready_o}, 32'd0);
    take_beat(30'hC3, 4'b1111, 32'hA3A3_A3A3, 1'b0, "R8");
    take_beat(30'hC4, 4'b1111, 32'hA4A4_A4A4, 1'b1, "R5");
    #1;
    chk(wr_ready_o === 1'b1, "R5", "ready after drain", {31'd0, wr_ready_o}, 32'd1);
  endtask

  task automatic t_idle;
    idle_limit_i = 8'd5;
    cpu_wr(32'h400, 2'b00, 32'h0000_0077);
    for (int i = 0; i <= 5; i++) begin
      chk(bus_valid_o === 1'b0, "R7", "held before limit", {31'd0, bus_valid_o}, 32'd0);
      @(negedge clk_i);
    end
    chk(bus_valid_o === 1'b1, "R7", "sent at limit", {31'd0, bus_valid_o}, 32'd1);
    take_beat(30'h100, 4'b0001, 32'h0000_0077, 1'b1, "R7");
    idle_limit_i = 8'd200;
  endtask

  task automatic t_no_merge;
    merge_en_i = 1'b0;
    cpu_wr(32'h500, 2'b00, 32'h0000_005A);
    chk(bus_valid_o === 1'b1, "R9", "sent at once", {31'd0, bus_valid_o}, 32'd1);
    cpu_wr(32'h501, 2'b00, 32'h0000_6B00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(bus_valid_o === 1'b1 && bus_waddr_o === 30'h140 && bus_be_o === 4'b0001,
          "R10", "beat held under backpressure", {28'd0, bus_be_o}, 32'h1);
    end
    take_beat(30'h140, 4'b0001, 32'h0000_005A, 1'b1, "R9");
    take_beat(30'h140, 4'b0010, 32'h0000_6B00, 1'b1, "R9");
  endtask

  task automatic t_sizes;
    cpu_wr(32'h603, 2'b10, 32'hDEAD_BEEF);
    cpu_wr(32'h601, 2'b01, 32'h0000_1234);
    cpu_wr(32'h607, 2'b01, 32'h9876_0000);
    cpu_wr(32'h602, 2'b00, 32'h00C3_0000);
    take_beat(30'h180, 4'b1111, 32'hDEAD_BEEF, 1'b1, "R2");
    take_beat(30'h180, 4'b0011, 32'h0000_1234, 1'b1, "R2");
    take_beat(30'h181, 4'b1100, 32'h9876_0000, 1'b1, "R2");
    take_beat(30'h180, 4'b0100, 32'h00C3_0000, 1'b1, "R2");
    merge_en_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_merge_flush();
    t_overwrite_burst();
    t_full_gap();
    t_idle();
    t_no_merge();
    t_sizes();
    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule